// File: doc/BRIEF.md
# Label-Masked Cache Victim Selector

This block chooses the replacement victim for a set-associative shared cache, and it limits that choice according to the label carried by the requester. Each label owns a way-mask entry in a small table. When a lookup starts, the block reads the entry for the request's label and latches it. The cache metadata for the set arrives one cycle later. At that point the block filters the candidate ways through the latched mask, so only enabled ways can be picked for allocation.

Giving labels disjoint masks splits the cache capacity between traffic classes. For example, one class can take the upper four ways (mask 0xF000) and another the lower twelve (mask 0x0FFF). Hits are never restricted, because no victim is produced when the lookup hits. Inside the masked set, an empty way is taken first. When every masked way is full, a per-set rotating pointer chooses the victim. A label whose mask is all zero may use every way, so a misconfigured mask cannot block allocation.

Top module: `lbl_victim_sel`

## Requirements
- R1: After reset every mask entry enables all ways. A lookup with all ways valid and pointer 0 yields way 0 for any label.
- R2: On a miss, the victim way always has its bit set in the mask of the looked-up label, where bit i of the mask stands for way i.
- R3: If any masked way has its valid bit clear, the victim is the lowest-numbered such way.
- R4: If every masked way is valid, the victim is the first masked way found by scanning upward from the replacement pointer and wrapping from the top way to way 0.
- R5: A mask entry of zero acts as all ones.
- R6: When the hit flag is high in the metadata cycle, no victim is produced (the victim-valid output stays low).
- R7: The victim-valid output is high only in the cycle right after a lookup start, and never in the cycle of the start itself.
- R8: A mask write in the same cycle as a lookup start has no effect on that lookup, which uses the old entry. A write in the metadata cycle has no effect on the lookup already in flight.
- R9: A mask write changes only the entry of the label it addresses. Every other label keeps its own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_start | input | 1 | Lookup start, one-cycle pulse |
| lk_label | input | LABEL_W | Requester label for the lookup |
| md_valid | input | NUM_WAYS | Valid bits of the set, presented the cycle after start |
| md_ptr | input | log2(NUM_WAYS) | Replacement pointer of the set, same cycle as md_valid |
| md_hit | input | 1 | Lookup hit flag, same cycle as md_valid |
| mw_en | input | 1 | Mask table write enable |
| mw_label | input | LABEL_W | Mask table write address |
| mw_mask | input | NUM_WAYS | Mask value to write |
| vic_valid | output | 1 | A victim is being reported this cycle |
| vic_way | output | log2(NUM_WAYS) | Chosen victim way |

## Verification
On every cycle, the assertions check four things: the victim lies inside the latched mask, an empty masked way wins whenever one exists, no victim appears on a hit or outside the cycle after a start, and the latched mask is never zero. Some behaviours are visible only through the bench's scenarios. These are the rotating-pointer order with wrap-around, the all-ones reset contents, the zero-mask fallback, the old-value rule for writes that overlap a lookup, and the independence of the per-label entries.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
   typedef enum logic {
      PICK_LOWEST = 1'b0,
      PICK_ROTATE = 1'b1
   } pick_mode_e;
endpackage

// File: rtl/lvs_mask_table.sv
module lvs_mask_table #(
   parameter int NUM_WAYS = 16,
   parameter int LABEL_W  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [LABEL_W-1:0]  rd_label,
   input  logic                wr_en,
   input  logic [LABEL_W-1:0]  wr_label,
   input  logic [NUM_WAYS-1:0] wr_mask,
   output logic                held_vld,
   output logic [NUM_WAYS-1:0] held_mask
);
   localparam int DEPTH = 1 << LABEL_W;

   logic [NUM_WAYS-1:0] tbl [DEPTH];
   logic [NUM_WAYS-1:0] rd_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '1;
      end else if (wr_en) begin
         tbl[wr_label] <= wr_mask;
      end
   end

   assign rd_raw = tbl[rd_label];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_vld  <= 1'b0;
         held_mask <= '1;
      end else begin
         held_vld <= rd_en;
         if (rd_en) held_mask <= (rd_raw == '0) ? '1 : rd_raw;
      end
   end

   assert_mask_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      held_vld |-> (held_mask != '0));
endmodule

// File: rtl/lvs_way_pick.sv
module lvs_way_pick #(
   parameter int                 NUM_WAYS = 16,
   parameter lvs_pkg::pick_mode_e MODE    = lvs_pkg::PICK_ROTATE,
   localparam int                IDX_W    = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] allow,
   input  logic [NUM_WAYS-1:0] valid,
   input  logic [IDX_W-1:0]    ptr,
   output logic [IDX_W-1:0]    way
);
   logic [NUM_WAYS-1:0] free_c;
   logic [IDX_W-1:0]    free_idx;
   logic                free_any;
   logic [IDX_W-1:0]    full_idx;

   assign free_c = allow & ~valid;

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         if (free_c[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   generate
      if (MODE == lvs_pkg::PICK_ROTATE) begin : g_rotate
         logic [2*NUM_WAYS-1:0] dbl;
         logic [NUM_WAYS-1:0]   rot;
         logic [IDX_W-1:0]      off;
         assign dbl = {allow, allow} >> ptr;
         assign rot = dbl[NUM_WAYS-1:0];
         always_comb begin
            off = '0;
            for (int i = NUM_WAYS - 1; i >= 0; i--) begin
               if (rot[i]) off = IDX_W'(i);
            end
         end
         assign full_idx = ptr + off;
      end else begin : g_lowest
         always_comb begin
            full_idx = '0;
            for (int i = NUM_WAYS - 1; i >= 0; i--) begin
               if (allow[i]) full_idx = IDX_W'(i);
            end
         end
      end
   endgenerate

   assign way = free_any ? free_idx : full_idx;
endmodule

// File: rtl/lbl_victim_sel.sv
module lbl_victim_sel #(
   parameter int                 NUM_WAYS = 16,
   parameter int                 LABEL_W  = 5,
   parameter lvs_pkg::pick_mode_e MODE    = lvs_pkg::PICK_ROTATE,
   localparam int                IDX_W    = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lk_start,
   input  logic [LABEL_W-1:0]  lk_label,
   input  logic [NUM_WAYS-1:0] md_valid,
   input  logic [IDX_W-1:0]    md_ptr,
   input  logic                md_hit,
   input  logic                mw_en,
   input  logic [LABEL_W-1:0]  mw_label,
   input  logic [NUM_WAYS-1:0] mw_mask,
   output logic                vic_valid,
   output logic [IDX_W-1:0]    vic_way
);
   generate
      if (NUM_WAYS < 2 || (1 << IDX_W) != NUM_WAYS) begin : g_bad_ways
         $error("NUM_WAYS must be a power of two, at least 2");
      end
      if (LABEL_W < 1 || LABEL_W > 8) begin : g_bad_label
         $error("LABEL_W must lie in 1..8");
      end
   endgenerate

   logic                s1_vld;
   logic [NUM_WAYS-1:0] s1_mask;

   lvs_mask_table #(.NUM_WAYS(NUM_WAYS), .LABEL_W(LABEL_W)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (lk_start),
      .rd_label  (lk_label),
      .wr_en     (mw_en),
      .wr_label  (mw_label),
      .wr_mask   (mw_mask),
      .held_vld  (s1_vld),
      .held_mask (s1_mask)
   );

   lvs_way_pick #(.NUM_WAYS(NUM_WAYS), .MODE(MODE)) u_pick (
      .allow (s1_mask),
      .valid (md_valid),
      .ptr   (md_ptr),
      .way   (vic_way)
   );

   assign vic_valid = s1_vld & ~md_hit;

   assert_victim_in_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> s1_mask[vic_way]);
   assert_free_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && ((s1_mask & ~md_valid) != '0)) |-> !md_valid[vic_way]);
   assert_no_victim_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      md_hit |-> !vic_valid);
   assert_victim_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> $past(lk_start));
endmodule

// File: tb/tb_lbl_victim_sel.sv
module tb_lbl_victim_sel;
   localparam int NW = 16;
   localparam int LW = 5;
   localparam int IW = 4;

   typedef struct {
      logic          vld;
      logic [IW-1:0] way;
      string         req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_start = 1'b0;
   logic [LW-1:0] lk_label = '0;
   logic [NW-1:0] md_valid = '0;
   logic [IW-1:0] md_ptr = '0;
   logic md_hit = 1'b0;
   logic mw_en = 1'b0;
   logic [LW-1:0] mw_label = '0;
   logic [NW-1:0] mw_mask = '0;
   logic vic_valid;
   logic [IW-1:0] vic_way;

   int total = 0;
   int bad = 0;
   exp_t q[$];
   logic [NW-1:0] model [32];

   always #2.5 clk = ~clk;

   lbl_victim_sel dut (.*);

   function automatic logic [IW-1:0] ref_pick(logic [NW-1:0] m, logic [NW-1:0] v, logic [IW-1:0] p);
      logic [NW-1:0] a;
      a = (m == '0) ? '1 : m;
      for (int i = 0; i < NW; i++) if (a[i] && !v[i]) return IW'(i);
      for (int i = 0; i < NW; i++) if (a[(p + i) % NW]) return IW'((p + i) % NW);
      return '0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wr(input logic [LW-1:0] l, input logic [NW-1:0] m);
      @(negedge clk);
      mw_en = 1'b1; mw_label = l; mw_mask = m;
      @(negedge clk);
      mw_en = 1'b0;
      model[l] = m;
   endtask

   // wmode 0: no write, 1: write in start cycle, 2: write in metadata cycle
   task automatic lookup(input logic [LW-1:0] l, input logic [NW-1:0] v, input logic [IW-1:0] p,
                         input logic hit, input string req,
                         input int wmode = 0, input logic [NW-1:0] wm = '0);
      exp_t e;
      @(negedge clk);
      lk_start = 1'b1; lk_label = l;
      if (wmode == 1) begin mw_en = 1'b1; mw_label = l; mw_mask = wm; end
      #1 check(vic_valid === 1'b0, "R7", int'(vic_valid), 0);
      @(negedge clk);
      lk_start = 1'b0; mw_en = 1'b0;
      md_valid = v; md_ptr = p; md_hit = hit;
      if (wmode == 2) begin mw_en = 1'b1; mw_label = l; mw_mask = wm; end
      e.vld = !hit;
      e.way = ref_pick(model[l], v, p);
      e.req = req;
      q.push_back(e);
      if (wmode != 0) model[l] = wm;
      @(negedge clk);
      mw_en = 1'b0; md_hit = 1'b0;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            check(vic_valid === e.vld, {e.req, " valid"}, int'(vic_valid), int'(e.vld));
            if (e.vld) check(vic_way === e.way, e.req, int'(vic_way), int'(e.way));
         end else if (rst_n && vic_valid) begin
            check(1'b0, "R7 spurious", 1, 0);
         end
      end
   end

   initial begin : watchdog
      #200000;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : driver
      for (int i = 0; i < 32; i++) model[i] = '1;
      repeat (3) @(negedge clk);
      check(vic_valid === 1'b0, "R1 reset", int'(vic_valid), 0);
      rst_n = 1'b1;
      lookup(5'd3, 16'hFFFF, 4'd0, 1'b0, "R1");
      lookup(5'd31, 16'hFFFF, 4'd0, 1'b0, "R1");
      wr(5'd1, 16'hF000);
      wr(5'd2, 16'h0FFF);
      lookup(5'd1, 16'hFFFF, 4'd0, 1'b0, "R2 R4");
      lookup(5'd1, 16'hFFFF, 4'd14, 1'b0, "R4");
      lookup(5'd2, 16'hFFFF, 4'd13, 1'b0, "R4 wrap");
      lookup(5'd2, 16'hFFFF, 4'd5, 1'b0, "R2");
      lookup(5'd1, 16'hBFFF, 4'd0, 1'b0, "R3");
      lookup(5'd2, 16'hFFF5, 4'd9, 1'b0, "R3");
      lookup(5'd1, 16'h0000, 4'd3, 1'b0, "R3 R2");
      wr(5'd4, 16'h0000);
      lookup(5'd4, 16'hFFFF, 4'd7, 1'b0, "R5");
      lookup(5'd4, 16'hFF7F, 4'd2, 1'b0, "R5");
      lookup(5'd1, 16'h0000, 4'd0, 1'b1, "R6");
      lookup(5'd2, 16'hFFFF, 4'd0, 1'b1, "R6");
      lookup(5'd6, 16'hFFFF, 4'd9, 1'b0, "R8 same", 1, 16'h0003);
      lookup(5'd6, 16'hFFFF, 4'd9, 1'b0, "R8 new");
      lookup(5'd7, 16'hFFFF, 4'd2, 1'b0, "R8 late", 2, 16'h0100);
      lookup(5'd7, 16'hFFFF, 4'd2, 1'b0, "R8 new");
      lookup(5'd3, 16'hFFFF, 4'd5, 1'b0, "R9");
      lookup(5'd1, 16'hFFFF, 4'd6, 1'b0, "R9");
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R7 drain", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule